// File: doc/BRIEF.md
# Predicated Commit Controller

This block sits at the retire end of a statically scheduled pipeline. It holds a file of one-bit predicate registers and decides, one instruction per cycle, whether that instruction's result may change architectural state. Each ordinary instruction names a qualifying predicate. If that predicate reads one, the register-file and memory write enables pass through. If it reads zero, the instruction is squashed and both enables stay low. Equality compares are the only producers of predicates. Each compare writes two destinations: one gets the comparison outcome and the other gets its inverse.

Instructions arrive in groups. A group is closed by an instruction that carries the stop flag. The compiler promises that no instruction in a group depends on an earlier one in the same group. For that reason, predicate writes from a compare are held back and only become visible to the group that follows. An optional checker watches each group. It raises a hazard flag when an instruction reads or overwrites a predicate or a general register that an earlier instruction of the same group has already written. The ALUs, branches and memory lie outside this block. It only sees the compare operands, the register indices and the result value.

Top module: `pe_commit_ctrl`

## Requirements
- R1: After reset every predicate except index 0 reads zero, so an instruction qualified by any nonzero index is squashed until a compare has set that predicate.
- R2: Predicate index 0 always reads one and ignores compare writes; an instruction qualified by index 0 is never squashed.
- R3: An ordinary instruction whose qualifying predicate is one produces, on the cycle after it is presented, out_valid=1, out_squash=0, out_rf_we equal to in_gpr_we, out_mem_we equal to in_mem_we, and the destination index and result on out_rf_addr and out_rf_data.
- R4: An instruction whose qualifying predicate is zero produces out_valid=1 and out_squash=1 on the following cycle, with out_rf_we=0 and out_mem_we=0.
- R5: A compare (in_is_cmp=1) whose qualifying predicate is one writes (in_cmp_a == in_cmp_b) to predicate in_pd_true and the inverse to in_pd_false. A compare never asserts out_rf_we or out_mem_we.
- R6: A compare whose qualifying predicate is zero writes no predicate and is reported with out_squash=1.
- R7: Predicate writes become visible only after the instruction carrying in_stop=1 has been accepted. Later instructions in the same group still read the value from before the group.
- R8: With the checker enabled, out_hazard=1 flags an instruction whose nonzero qualifying predicate, or whose nonzero compare destination, was already a compare destination earlier in the same group. A compare that names the same nonzero index for both destinations is also flagged. This holds whatever the predicate values are.
- R9: With the checker enabled, out_hazard=1 flags an instruction that reads (in_src_a_en/in_src_b_en) or writes (in_gpr_we on a non-compare) a general register already written by a non-compare earlier in the same group.
- R10: The instruction carrying in_stop=1 is itself checked against its group. After it, all group tracking is cleared, so reusing the same registers in the next group raises no hazard.
- R11: The out_* signals are registered one cycle after the input. After a cycle with in_valid=0, all out_* flags and enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_stop | input | 1 | This instruction closes its group |
| in_is_cmp | input | 1 | Instruction is an equality compare |
| in_qp | input | 6 | Qualifying predicate index |
| in_pd_true | input | 6 | Compare destination receiving the outcome |
| in_pd_false | input | 6 | Compare destination receiving the inverse |
| in_cmp_a | input | 32 | First compare operand |
| in_cmp_b | input | 32 | Second compare operand |
| in_src_a_en | input | 1 | First source register is read |
| in_src_a | input | 5 | First source register index |
| in_src_b_en | input | 1 | Second source register is read |
| in_src_b | input | 5 | Second source register index |
| in_gpr_we | input | 1 | Instruction writes a general register |
| in_gpr_dst | input | 5 | Destination register index |
| in_mem_we | input | 1 | Instruction writes memory |
| in_result | input | 32 | Result value to be committed |
| out_valid | output | 1 | An instruction retired last cycle |
| out_squash | output | 1 | That instruction was discarded |
| out_rf_we | output | 1 | Register-file write enable |
| out_rf_addr | output | 5 | Register-file write index |
| out_rf_data | output | 32 | Register-file write data |
| out_mem_we | output | 1 | Memory write enable |
| out_hazard | output | 1 | Intra-group dependence detected |

## Verification
The hardest situation to reach is a reader placed in the same group as the compare that produces its predicate. The reader must see the old value, and the checker must flag it in the same cycle. Reaching this needs a compare and its consumer back to back with no stop between them. A later group is then needed to show that the new value has landed. The bench builds such groups directly, including a compare that targets index 0 and a compare whose own qualifier is false. It then runs a long random stream over a small set of indices, so that intra-group collisions and stop boundaries occur often, and compares every cycle against a behavioural model.

// File: rtl/pe_commit_pkg.sv
package pe_commit_pkg;

    typedef struct packed {
        logic valid;
        logic squash;
        logic rf_we;
        logic mem_we;
        logic hazard;
    } cmt_flags_t;

endpackage

// File: rtl/pe_pred_file.sv
module pe_pred_file #(
    parameter int NPRED = 64,
    localparam int PW = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_idx,
    output logic          rd_val,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx_t,
    input  logic [PW-1:0] wr_idx_f,
    input  logic          wr_val,
    input  logic          grp_end
);

    typedef struct packed {
        logic [NPRED-1:0] file;
        logic [NPRED-1:0] pval;
        logic [NPRED-1:0] pmsk;
    } pf_state_t;

    pf_state_t st_d, st_q;

    // pending writes merge into the visible file only at a group end
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_idx_t != '0) begin
                st_d.pval[wr_idx_t] = wr_val;
                st_d.pmsk[wr_idx_t] = 1'b1;
            end
            if (wr_idx_f != '0) begin
                st_d.pval[wr_idx_f] = ~wr_val;
                st_d.pmsk[wr_idx_f] = 1'b1;
            end
        end
        if (grp_end) begin
            st_d.file = (st_q.file & ~st_d.pmsk) | (st_d.pval & st_d.pmsk);
            st_d.pval = '0;
            st_d.pmsk = '0;
        end
        st_d.file[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.file <= {{(NPRED-1){1'b0}}, 1'b1};
            st_q.pval <= '0;
            st_q.pmsk <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_val = st_q.file[rd_idx];

endmodule

// File: rtl/pe_group_hazard.sv
module pe_group_hazard #(
    parameter int NPRED    = 64,
    parameter int NGPR     = 32,
    parameter bit CHECK_EN = 1'b1,
    localparam int PW = $clog2(NPRED),
    localparam int GW = $clog2(NGPR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          is_cmp,
    input  logic          stop,
    input  logic [PW-1:0] qp,
    input  logic [PW-1:0] pd_t,
    input  logic [PW-1:0] pd_f,
    input  logic          src_a_en,
    input  logic [GW-1:0] src_a,
    input  logic          src_b_en,
    input  logic [GW-1:0] src_b,
    input  logic          gpr_we,
    input  logic [GW-1:0] gpr_dst,
    output logic          hazard
);

    generate
        if (CHECK_EN) begin : g_on
            typedef struct packed {
                logic [NPRED-1:0] pw;
                logic [NGPR-1:0]  gw;
            } hz_state_t;

            hz_state_t st_d, st_q;
            logic      hz;

            always_comb begin
                st_d = st_q;
                hz   = 1'b0;
                if (valid) begin
                    if (qp != '0 && st_q.pw[qp])      hz = 1'b1;
                    if (src_a_en && st_q.gw[src_a])   hz = 1'b1;
                    if (src_b_en && st_q.gw[src_b])   hz = 1'b1;
                    if (is_cmp) begin
                        if (pd_t != '0 && st_q.pw[pd_t]) hz = 1'b1;
                        if (pd_f != '0 && st_q.pw[pd_f]) hz = 1'b1;
                        if (pd_t != '0 && pd_t == pd_f)  hz = 1'b1;
                        if (pd_t != '0) st_d.pw[pd_t] = 1'b1;
                        if (pd_f != '0) st_d.pw[pd_f] = 1'b1;
                    end else if (gpr_we) begin
                        if (st_q.gw[gpr_dst]) hz = 1'b1;
                        st_d.gw[gpr_dst] = 1'b1;
                    end
                    if (stop) begin
                        st_d.pw = '0;
                        st_d.gw = '0;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign hazard = hz;
        end else begin : g_off
            assign hazard = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pe_commit_stage.sv
module pe_commit_stage
    import pe_commit_pkg::*;
#(
    parameter int NGPR   = 32,
    parameter int DATA_W = 32,
    localparam int GW = $clog2(NGPR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              is_cmp,
    input  logic              pred,
    input  logic              gpr_we,
    input  logic              mem_we,
    input  logic [GW-1:0]     dst,
    input  logic [DATA_W-1:0] data,
    input  logic              hazard,
    output cmt_flags_t        flags,
    output logic [GW-1:0]     addr,
    output logic [DATA_W-1:0] wdata
);

    typedef struct packed {
        cmt_flags_t        f;
        logic [GW-1:0]     addr;
        logic [DATA_W-1:0] data;
    } cs_state_t;

    cs_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (valid) begin
            st_d.f.valid  = 1'b1;
            st_d.f.squash = ~pred;
            st_d.f.rf_we  = ~is_cmp & pred & gpr_we;
            st_d.f.mem_we = ~is_cmp & pred & mem_we;
            st_d.f.hazard = hazard;
            st_d.addr     = dst;
            st_d.data     = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.f;
    assign addr  = st_q.addr;
    assign wdata = st_q.data;

endmodule

// File: rtl/pe_commit_ctrl.sv
module pe_commit_ctrl
    import pe_commit_pkg::*;
#(
    parameter int NPRED    = 64,
    parameter int NGPR     = 32,
    parameter int DATA_W   = 32,
    parameter bit CHECK_EN = 1'b1,
    localparam int PW = $clog2(NPRED),
    localparam int GW = $clog2(NGPR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_stop,
    input  logic              in_is_cmp,
    input  logic [PW-1:0]     in_qp,
    input  logic [PW-1:0]     in_pd_true,
    input  logic [PW-1:0]     in_pd_false,
    input  logic [DATA_W-1:0] in_cmp_a,
    input  logic [DATA_W-1:0] in_cmp_b,
    input  logic              in_src_a_en,
    input  logic [GW-1:0]     in_src_a,
    input  logic              in_src_b_en,
    input  logic [GW-1:0]     in_src_b,
    input  logic              in_gpr_we,
    input  logic [GW-1:0]     in_gpr_dst,
    input  logic              in_mem_we,
    input  logic [DATA_W-1:0] in_result,
    output logic              out_valid,
    output logic              out_squash,
    output logic              out_rf_we,
    output logic [GW-1:0]     out_rf_addr,
    output logic [DATA_W-1:0] out_rf_data,
    output logic              out_mem_we,
    output logic              out_hazard
);

    logic       pred;
    logic       cmp_wr;
    logic       cmp_eq;
    logic       grp_end;
    logic       hazard;
    cmt_flags_t flags;

    assign cmp_eq  = (in_cmp_a == in_cmp_b);
    assign cmp_wr  = in_valid & in_is_cmp & pred;
    assign grp_end = in_valid & in_stop;

    pe_pred_file #(.NPRED(NPRED)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (in_qp),
        .rd_val   (pred),
        .wr_en    (cmp_wr),
        .wr_idx_t (in_pd_true),
        .wr_idx_f (in_pd_false),
        .wr_val   (cmp_eq),
        .grp_end  (grp_end)
    );

    pe_group_hazard #(.NPRED(NPRED), .NGPR(NGPR), .CHECK_EN(CHECK_EN)) u_hz (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (in_valid),
        .is_cmp   (in_is_cmp),
        .stop     (in_stop),
        .qp       (in_qp),
        .pd_t     (in_pd_true),
        .pd_f     (in_pd_false),
        .src_a_en (in_src_a_en),
        .src_a    (in_src_a),
        .src_b_en (in_src_b_en),
        .src_b    (in_src_b),
        .gpr_we   (in_gpr_we),
        .gpr_dst  (in_gpr_dst),
        .hazard   (hazard)
    );

    pe_commit_stage #(.NGPR(NGPR), .DATA_W(DATA_W)) u_cs (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (in_valid),
        .is_cmp (in_is_cmp),
        .pred   (pred),
        .gpr_we (in_gpr_we),
        .mem_we (in_mem_we),
        .dst    (in_gpr_dst),
        .data   (in_result),
        .hazard (hazard),
        .flags  (flags),
        .addr   (out_rf_addr),
        .wdata  (out_rf_data)
    );

    assign out_valid  = flags.valid;
    assign out_squash = flags.squash;
    assign out_rf_we  = flags.rf_we;
    assign out_mem_we = flags.mem_we;
    assign out_hazard = flags.hazard;

endmodule

// File: rtl/pe_commit_ctrl_chk.sv
module pe_commit_ctrl_chk #(
    parameter int NPRED  = 64,
    parameter int NGPR   = 32,
    parameter int DATA_W = 32,
    localparam int PW = $clog2(NPRED),
    localparam int GW = $clog2(NGPR)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_is_cmp,
    input logic [PW-1:0]     in_qp,
    input logic              in_gpr_we,
    input logic [GW-1:0]     in_gpr_dst,
    input logic [DATA_W-1:0] in_result,
    input logic              out_valid,
    input logic              out_squash,
    input logic              out_rf_we,
    input logic [GW-1:0]     out_rf_addr,
    input logic [DATA_W-1:0] out_rf_data,
    input logic              out_mem_we,
    input logic              out_hazard
);

    // R4
    squash_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_squash |-> (!out_rf_we && !out_mem_we));

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_squash && !out_rf_we && !out_mem_we && !out_hazard));

    // R2
    p0_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_cmp && in_qp == '0) |=> !out_squash);

    // R3
    commit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_cmp && in_qp == '0 && in_gpr_we) |=>
        (out_rf_we && out_rf_addr == $past(in_gpr_dst) && out_rf_data == $past(in_result)));

    // R5
    cmp_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_cmp) |=> (!out_rf_we && !out_mem_we));

endmodule

bind pe_commit_ctrl pe_commit_ctrl_chk #(.NPRED(NPRED), .NGPR(NGPR), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pe_commit_ctrl_test.sv
module pe_commit_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, in_stop = 0, in_is_cmp = 0;
    logic [5:0]  in_qp = 0, in_pd_true = 0, in_pd_false = 0;
    logic [31:0] in_cmp_a = 0, in_cmp_b = 0, in_result = 0;
    logic        in_src_a_en = 0, in_src_b_en = 0, in_gpr_we = 0, in_mem_we = 0;
    logic [4:0]  in_src_a = 0, in_src_b = 0, in_gpr_dst = 0;
    logic        out_valid, out_squash, out_rf_we, out_mem_we, out_hazard;
    logic [4:0]  out_rf_addr;
    logic [31:0] out_rf_data;

    int n_checks = 0;
    int n_fails  = 0;

    bit mpred [64];
    bit mpv   [64];
    bit mpm   [64];
    bit mpw   [64];
    bit mgw   [32];

    always #10 clk = ~clk;

    pe_commit_ctrl uut (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // presented at a negedge, checked at the next negedge
    task automatic issue(string tag, bit cmp, bit stop, int qp, int pdt, int pdf,
                         int a, int b, bit sae, int sa, bit sbe, int sb,
                         bit gwe, int dst, bit mwe, int data);
        bit p, e_rf, e_mem, e_hz;
        p     = (qp == 0) ? 1'b1 : mpred[qp];
        e_rf  = !cmp && p && gwe;
        e_mem = !cmp && p && mwe;
        e_hz  = (qp != 0 && mpw[qp]) || (sae && mgw[sa]) || (sbe && mgw[sb]);
        if (cmp)
            e_hz = e_hz || (pdt != 0 && mpw[pdt]) || (pdf != 0 && mpw[pdf]) || (pdt != 0 && pdt == pdf);
        else if (gwe)
            e_hz = e_hz || mgw[dst];
        in_valid = 1; in_is_cmp = cmp; in_stop = stop; in_qp = qp[5:0];
        in_pd_true = pdt[5:0]; in_pd_false = pdf[5:0]; in_cmp_a = a; in_cmp_b = b;
        in_src_a_en = sae; in_src_a = sa[4:0]; in_src_b_en = sbe; in_src_b = sb[4:0];
        in_gpr_we = gwe; in_gpr_dst = dst[4:0]; in_mem_we = mwe; in_result = data;
        if (cmp) begin
            if (pdt != 0) mpw[pdt] = 1;
            if (pdf != 0) mpw[pdf] = 1;
            if (p) begin
                if (pdt != 0) begin mpv[pdt] = (a == b); mpm[pdt] = 1; end
                if (pdf != 0) begin mpv[pdf] = (a != b); mpm[pdf] = 1; end
            end
        end else if (gwe) begin
            mgw[dst] = 1;
        end
        if (stop) begin
            for (int i = 1; i < 64; i++) begin
                if (mpm[i]) mpred[i] = mpv[i];
                mpm[i] = 0; mpv[i] = 0; mpw[i] = 0;
            end
            for (int i = 0; i < 32; i++) mgw[i] = 0;
        end
        @(negedge clk);
        chk(tag, "valid", out_valid, 1);
        chk(tag, "squash", out_squash, !p);
        chk(tag, "rf_we", out_rf_we, e_rf);
        chk(tag, "mem_we", out_mem_we, e_mem);
        chk(tag, "hazard", out_hazard, e_hz);
        if (e_rf) begin
            chk(tag, "rf_addr", out_rf_addr, dst);
            chk(tag, "rf_data", out_rf_data, data);
        end
    endtask

    task automatic alu(string tag, int qp, bit stop, bit gwe, int dst, bit mwe, int data);
        issue(tag, 0, stop, qp, 0, 0, 0, 0, 0, 0, 0, 0, gwe, dst, mwe, data);
    endtask

    task automatic cmpi(string tag, int qp, bit stop, int pdt, int pdf, int a, int b);
        issue(tag, 1, stop, qp, pdt, pdf, a, b, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(string tag);
        in_valid = 0; in_stop = 0; in_is_cmp = 0; in_gpr_we = 0; in_mem_we = 0;
        in_src_a_en = 0; in_src_b_en = 0;
        @(negedge clk);
        chk(tag, "idle flags", {out_valid, out_squash, out_rf_we, out_mem_we, out_hazard}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin mpred[i] = (i == 0); mpv[i] = 0; mpm[i] = 0; mpw[i] = 0; end
        for (int i = 0; i < 32; i++) mgw[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk("R11", "reset flags", {out_valid, out_squash, out_rf_we, out_mem_we, out_hazard}, 0);
        idle("R11");
        // R1 / R4: nonzero predicate reads zero after reset
        alu("R1", 5, 1, 1, 3, 1, 32'h11);
        // R2 / R3: p0 always commits
        alu("R3", 0, 1, 1, 3, 1, 32'hCAFE);
        // R7: same-group reader sees old value (and R8 flags it)
        cmpi("R5", 0, 0, 1, 2, 7, 7);
        alu("R7", 1, 1, 1, 4, 0, 32'h22);
        alu("R7", 1, 0, 1, 4, 0, 32'h23);
        alu("R5", 2, 1, 1, 4, 0, 32'h24);
        // R5: unequal compare
        cmpi("R5", 0, 1, 3, 4, 1, 2);
        alu("R5", 3, 0, 1, 6, 0, 32'h30);
        alu("R5", 4, 1, 1, 7, 0, 32'h31);
        // R2: compare targeting p0 is ignored
        cmpi("R2", 0, 1, 0, 6, 5, 9);
        alu("R2", 0, 0, 1, 8, 0, 32'h40);
        alu("R2", 6, 1, 1, 9, 0, 32'h41);
        // R6: compare with false qualifier writes nothing
        cmpi("R6", 3, 1, 7, 8, 4, 4);
        alu("R6", 7, 0, 0, 0, 0, 0);
        alu("R6", 8, 1, 0, 0, 0, 0);
        // R4: memory write squashed / committed
        alu("R4", 3, 1, 0, 0, 1, 32'h50);
        alu("R3", 4, 1, 0, 0, 1, 32'h51);
        // R9: GPR RAW and WAW inside a group
        alu("R9", 0, 0, 1, 5, 0, 32'h60);
        issue("R9", 0, 0, 0, 0, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0);
        alu("R9", 0, 1, 1, 5, 0, 32'h61);
        // R10: next group reuses r5 without hazard
        issue("R10", 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 5, 1, 5, 0, 32'h62);
        // R8: predicate WAW and duplicate destinations
        cmpi("R8", 0, 0, 9, 10, 1, 1);
        cmpi("R8", 0, 0, 10, 11, 1, 1);
        cmpi("R8", 0, 1, 12, 12, 1, 1);
        idle("R11");
        // random stream against the model
        for (int i = 0; i < 600; i++) begin
            bit c;
            c = ($urandom_range(0, 2) == 0);
            issue("R3", c, $urandom_range(0, 2) == 0, $urandom_range(0, 12),
                  $urandom_range(0, 12), $urandom_range(0, 12),
                  $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 1), $urandom_range(0, 7),
                  $urandom_range(0, 1), $urandom_range(0, 7),
                  $urandom_range(0, 1), $urandom_range(0, 7),
                  $urandom_range(0, 1), $urandom);
            if ($urandom_range(0, 9) == 0) idle("R11");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule